// File: doc/BRIEF.md
# System Control Register Bank

This block is a small bank of platform control and status words behind a word-addressed register bus. A host drives a byte address, a write strobe and write data. Read data is a combinational function of the address and current state, so every access finishes in the cycle it is presented. The bus has no stall path: a write is committed at the rising edge where the strobe is high.

The bank holds:
- a fixed identification word and a fixed status word;
- two oscillator setting words that only accept writes while a 16-bit unlock key sits in the key register;
- a control word with an LED bit, a memory-remap bit and a self-clearing reset-request bit;
- two pairs of set/clear flag addresses;
- a writable memory-init word;
- an SDRAM configuration word, whose size field is seeded at reset from a memory-size input;
- a read-only window of memory-module parameter bytes.

The remap bit drives an output that maps boot flash at address zero while the bit is clear. A software reset request leaves the block as a one-cycle pulse.

Top module: `sysctl_regbank`

## Requirements
- R1: Byte address 0x00 reads 0x411A3001, 0x04 reads 0, and 0x10 reads 0x00100000.
- R2: A write to the key register (0x14) stores only data bits [15:0]. Reading 0x14 returns 0x0001A05F while the stored key equals 0xA05F, and otherwise returns the stored 16 bits zero-extended.
- R3: Writes to the oscillator word (0x08) and the auxiliary oscillator word (0x1C) update them only while the stored key equals 0xA05F. Otherwise the words keep their values.
- R4: The control word (0x0C) stores only data bits 0 and 2, and reads back with every other bit zero, including bit 3. Output `led_on` equals stored bit 0.
- R5: A write to 0x0C with data bit 3 set makes `reset_req` high for exactly the following cycle. A control write with bit 3 clear raises no pulse.
- R6: `boot_flash_en` is 1 while control bit 2 (remap) is 0, and 0 while it is 1.
- R7: A write to 0x30 ORs the data into the flag word. A write to 0x34 clears the flag bits written as 1. The flag word reads at 0x30.
- R8: The non-volatile flag word works the same way: set at 0x38, clear at 0x3C, read at 0x38. It is independent of the R7 flags.
- R9: After reset, the oscillator reads 0x01000048, the auxiliary oscillator 0x0007FEFF, the init word (0x24) 0x00000112, the control word 0, both flag words 0, and the key 0.
- R10: After reset, the SDRAM word (0x20) reads 0x00011122 ORed with a size code taken from `mem_size_mb` while reset is held:
  - 0x10 for at least 256;
  - 0x0C for at least 128;
  - 0x08 for at least 64;
  - 0x04 for at least 32;
  - 0x00 below 32.
- R11: Byte addresses 0x100–0x17F read parameter byte (addr−0x100)/4, zero-extended, from a 32-entry table. The table starts 128, 8, 4, 11. Entry 30 is 0x28. Entry 31 is 64/32/16/4/2 for the five R10 size classes. Addresses 0x180–0x1FF read zero.
- R12: Voltage-control words 0x80–0x8C read zero, and writes to them change no state or output.
- R13: Every other address reads zero, including 0x18, 0x28, 0x34, 0x3C and 0x40. Writes to such addresses change no state and raise no pulse.
- R14: The SDRAM word and the init word take any 32-bit value written to them and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (9) | Byte address of the access |
| bus_wr | input | 1 | Write strobe, committed at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| mem_size_mb | input | SIZE_W (12) | Installed memory in MB, sampled during reset |
| led_on | output | 1 | LED drive, control bit 0 |
| boot_flash_en | output | 1 | High while boot flash is mapped at address zero |
| reset_req | output | 1 | One-cycle software reset request |

## Verification
The hardest situations to reach are the ones that depend on how state and strobes line up in time.

The R11 table entry and the R10 SDRAM size code change only through a new reset. The bench therefore re-enters reset with a different memory size for each of the five size classes, and reads both values after each reset.

The oscillator lock is a history condition. The bench writes the oscillator words with the key absent, then present, then replaced by a different value. Only the middle write may stick.

The reset-request pulse is sampled on the two cycles after the write, to show it is exactly one cycle wide.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DATA_W = 32;

  localparam logic [31:0] ID_WORD     = 32'h411A_3001;
  localparam logic [31:0] STAT_WORD   = 32'h0010_0000;
  localparam logic [31:0] OSC_RST     = 32'h0100_0048;
  localparam logic [31:0] AUX_RST     = 32'h0007_FEFF;
  localparam logic [31:0] INIT_RST    = 32'h0000_0112;
  localparam logic [31:0] SDRAM_BASE  = 32'h0001_1122;
  localparam logic [15:0] UNLOCK_KEY  = 16'hA05F;

  localparam int CTRL_LED_BIT   = 0;
  localparam int CTRL_REMAP_BIT = 2;
  localparam int CTRL_RST_BIT   = 3;

  // word indices inside the register page (byte address / 4)
  localparam logic [5:0] W_ID      = 6'd0;
  localparam logic [5:0] W_OSC     = 6'd2;
  localparam logic [5:0] W_CTRL    = 6'd3;
  localparam logic [5:0] W_STAT    = 6'd4;
  localparam logic [5:0] W_KEY     = 6'd5;
  localparam logic [5:0] W_AUX     = 6'd7;
  localparam logic [5:0] W_SDRAM   = 6'd8;
  localparam logic [5:0] W_INIT    = 6'd9;
  localparam logic [5:0] W_FLG_SET = 6'd12;
  localparam logic [5:0] W_FLG_CLR = 6'd13;
  localparam logic [5:0] W_NVF_SET = 6'd14;
  localparam logic [5:0] W_NVF_CLR = 6'd15;

  typedef enum logic [2:0] {
    SZ_SMALL, SZ_32M, SZ_64M, SZ_128M, SZ_256M
  } size_cls_t;

  function automatic size_cls_t classify(input logic [31:0] mb);
    if (mb >= 32'd256)      return SZ_256M;
    else if (mb >= 32'd128) return SZ_128M;
    else if (mb >= 32'd64)  return SZ_64M;
    else if (mb >= 32'd32)  return SZ_32M;
    else                    return SZ_SMALL;
  endfunction

  function automatic logic [7:0] sdram_code(input size_cls_t c);
    case (c)
      SZ_256M: return 8'h10;
      SZ_128M: return 8'h0C;
      SZ_64M:  return 8'h08;
      SZ_32M:  return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] param_byte(input logic [4:0] idx, input size_cls_t c);
    case (idx)
      5'd0:  return 8'd128;
      5'd1:  return 8'd8;
      5'd2:  return 8'd4;
      5'd3:  return 8'd11;
      5'd4:  return 8'd9;
      5'd5:  return 8'd1;
      5'd6:  return 8'd64;
      5'd8:  return 8'd2;
      5'd9:  return 8'hA0;
      5'd10: return 8'hA0;
      5'd13: return 8'd8;
      5'd15: return 8'd1;
      5'd16: return 8'h0E;
      5'd17: return 8'd4;
      5'd18: return 8'h1C;
      5'd19: return 8'd1;
      5'd20: return 8'd2;
      5'd21: return 8'h20;
      5'd22: return 8'hC0;
      5'd27: return 8'h30;
      5'd28: return 8'h28;
      5'd29: return 8'h30;
      5'd30: return 8'h28;
      5'd31: begin
        case (c)
          SZ_256M: return 8'd64;
          SZ_128M: return 8'd32;
          SZ_64M:  return 8'd16;
          SZ_32M:  return 8'd4;
          default: return 8'd2;
        endcase
      end
      default: return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_lock_osc.sv
module sysctl_lock_osc
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_we,
  input  logic              osc_we,
  input  logic              aux_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] key_rd,
  output logic [DATA_W-1:0] osc_q,
  output logic [DATA_W-1:0] aux_q,
  output logic              key_held
);
  localparam int KEY_W = 16;

  logic [KEY_W-1:0] key_q;

  assign key_held = (key_q == UNLOCK_KEY);
  assign key_rd   = {{(DATA_W-KEY_W-1){1'b0}}, key_held, key_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q <= '0;
      osc_q <= OSC_RST;
      aux_q <= AUX_RST;
    end else begin
      if (key_we)              key_q <= wdata[KEY_W-1:0];
      if (osc_we && key_held)  osc_q <= wdata;
      if (aux_we && key_held)  aux_q <= wdata;
    end
  end
endmodule

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic              led_on,
  output logic              boot_flash_en,
  output logic              reset_req
);
  logic led_q, remap_q, pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_q   <= 1'b0;
      remap_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= we && wdata[CTRL_RST_BIT];
      if (we) begin
        led_q   <= wdata[CTRL_LED_BIT];
        remap_q <= wdata[CTRL_REMAP_BIT];
      end
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_LED_BIT]   = led_q;
    ctrl_rd[CTRL_REMAP_BIT] = remap_q;
  end

  assign led_on        = led_q;
  assign boot_flash_en = !remap_q;
  assign reset_req     = pulse_q;
endmodule

// File: rtl/sysctl_flagpair.sv
module sysctl_flagpair
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] flags_q
);
  logic [DATA_W-1:0] set_mask, clr_mask;

  assign set_mask = set_we ? wdata : '0;
  assign clr_mask = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q | set_mask) & ~clr_mask;
  end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [SIZE_W-1:0] mem_size_mb,
  output logic              led_on,
  output logic              boot_flash_en,
  output logic              reset_req
);
  localparam int PAGE_W   = ADDR_W - 8;
  localparam int N_FLAGS  = 2;
  localparam logic [PAGE_W-1:0] PG_REGS  = PAGE_W'(0);
  localparam logic [PAGE_W-1:0] PG_PARAM = PAGE_W'(1);

  logic       reg_page, param_page, param_hi;
  logic [5:0] word;
  logic [4:0] param_idx;

  assign reg_page   = (bus_addr[ADDR_W-1:8] == PG_REGS);
  assign param_page = (bus_addr[ADDR_W-1:8] == PG_PARAM);
  assign param_hi   = bus_addr[7];
  assign word       = bus_addr[7:2];
  assign param_idx  = bus_addr[6:2];

  function automatic logic hit(input logic [5:0] w);
    return bus_wr && reg_page && (word == w);
  endfunction

  // lock + oscillators
  logic [DATA_W-1:0] key_rd, osc_q, aux_q;
  logic              key_held;

  sysctl_lock_osc u_lock (
    .clk(clk), .rst_n(rst_n),
    .key_we(hit(W_KEY)), .osc_we(hit(W_OSC)), .aux_we(hit(W_AUX)),
    .wdata(bus_wdata), .key_rd(key_rd), .osc_q(osc_q), .aux_q(aux_q),
    .key_held(key_held)
  );

  // control word
  logic [DATA_W-1:0] ctrl_rd;

  sysctl_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(hit(W_CTRL)), .wdata(bus_wdata),
    .ctrl_rd(ctrl_rd), .led_on(led_on), .boot_flash_en(boot_flash_en),
    .reset_req(reset_req)
  );

  // set/clear flag pairs: index 0 volatile, index 1 non-volatile
  logic [N_FLAGS-1:0] flg_set, flg_clr;
  logic [DATA_W-1:0]  flags_q [N_FLAGS];

  assign flg_set = {hit(W_NVF_SET), hit(W_FLG_SET)};
  assign flg_clr = {hit(W_NVF_CLR), hit(W_FLG_CLR)};

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flags
    sysctl_flagpair u_pair (
      .clk(clk), .rst_n(rst_n), .set_we(flg_set[g]), .clr_we(flg_clr[g]),
      .wdata(bus_wdata), .flags_q(flags_q[g])
    );
  end

  // memory size class, SDRAM and init words
  size_cls_t         size_q;
  logic [DATA_W-1:0] sdram_q, init_q;
  size_cls_t         size_now;

  assign size_now = classify(32'(mem_size_mb));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q  <= size_now;
      sdram_q <= SDRAM_BASE | {24'b0, sdram_code(size_now)};
      init_q  <= INIT_RST;
    end else begin
      if (hit(W_SDRAM)) sdram_q <= bus_wdata;
      if (hit(W_INIT))  init_q  <= bus_wdata;
    end
  end

  // parameter window
  logic [7:0] param_val;
  assign param_val = param_byte(param_idx, size_q);

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (param_page) begin
      if (!param_hi) bus_rdata = {24'b0, param_val};
    end else if (reg_page) begin
      case (word)
        W_ID:      bus_rdata = ID_WORD;
        W_OSC:     bus_rdata = osc_q;
        W_CTRL:    bus_rdata = ctrl_rd;
        W_STAT:    bus_rdata = STAT_WORD;
        W_KEY:     bus_rdata = key_rd;
        W_AUX:     bus_rdata = aux_q;
        W_SDRAM:   bus_rdata = sdram_q;
        W_INIT:    bus_rdata = init_q;
        W_FLG_SET: bus_rdata = flags_q[0];
        W_NVF_SET: bus_rdata = flags_q[1];
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              led_on,
  input logic              boot_flash_en,
  input logic              reset_req,
  input logic              key_held,
  input logic [31:0]       osc_q,
  input logic [31:0]       aux_q
);
  int a;
  assign a = int'(bus_addr);

  AST_ID_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (a == 0) |-> (bus_rdata == ID_WORD)); // R1

  AST_CTRL_LED: assert property (@(posedge clk) disable iff (!rst_n)
    (a == 12) |-> (bus_rdata[0] == led_on && !bus_rdata[3])); // R4

  AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(bus_wr && a == 12 && bus_wdata[3])); // R5

  AST_REMAP_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (a == 12) |-> (bus_rdata[2] == !boot_flash_en)); // R6

  AST_OSC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && a == 8 && !key_held) |=> $stable(osc_q)); // R3

  AST_AUX_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && a == 28 && !key_held) |=> $stable(aux_q)); // R3

  AST_VOLT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (a >= 128 && a < 144) |-> (bus_rdata == 32'h0)); // R12

  AST_PARAM_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (a >= 384 && a < 512) |-> (bus_rdata == 32'h0)); // R11
endmodule

bind sysctl_regbank sysctl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .led_on(led_on),
  .boot_flash_en(boot_flash_en), .reset_req(reset_req),
  .key_held(key_held), .osc_q(osc_q), .aux_q(aux_q)
);

// File: tb/sysctl_regbank_bench.sv
module sysctl_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] mem_size_mb = 12'd100;
  logic        led_on, boot_flash_en, reset_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sysctl_regbank u_sysctl_regbank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_size_mb(mem_size_mb),
    .led_on(led_on), .boot_flash_en(boot_flash_en), .reset_req(reset_req)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic [11:0] mb);
    @(negedge clk);
    bus_wr = 1'b0;
    mem_size_mb = mb;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] addr, input logic [31:0] data);
    @(negedge clk);
    bus_addr = addr;
    bus_wdata = data;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] addr, output logic [31:0] data);
    bus_addr = addr;
    #1;
    data = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [8:0] addr, input logic [31:0] exp);
    logic [31:0] v;
    rd(addr, v);
    check(req, v, exp);
  endtask

  task automatic t_reset_values;
    rdchk("R9 osc", 9'h008, 32'h0100_0048);
    rdchk("R9 aux", 9'h01C, 32'h0007_FEFF);
    rdchk("R9 init", 9'h024, 32'h0000_0112);
    rdchk("R9 ctrl", 9'h00C, 32'h0);
    rdchk("R9 flags", 9'h030, 32'h0);
    rdchk("R9 nvflags", 9'h038, 32'h0);
    rdchk("R9 key", 9'h014, 32'h0);
    rdchk("R10 sdram 100MB", 9'h020, 32'h0001_112A);
    check("R6 flash at reset", {31'b0, boot_flash_en}, 32'h1);
    check("R4 led at reset", {31'b0, led_on}, 32'h0);
    check("R5 no pulse at reset", {31'b0, reset_req}, 32'h0);
  endtask

  task automatic t_fixed;
    rdchk("R1 id", 9'h000, 32'h411A_3001);
    rdchk("R1 proc", 9'h004, 32'h0);
    rdchk("R1 status", 9'h010, 32'h0010_0000);
  endtask

  task automatic t_lock_osc;
    wr(9'h008, 32'h0000_1234);
    rdchk("R3 osc locked", 9'h008, 32'h0100_0048);
    wr(9'h01C, 32'h0000_5555);
    rdchk("R3 aux locked", 9'h01C, 32'h0007_FEFF);
    wr(9'h014, 32'hDEAD_A05F);
    rdchk("R2 key held", 9'h014, 32'h0001_A05F);
    wr(9'h008, 32'h0000_CAFE);
    rdchk("R3 osc unlocked", 9'h008, 32'h0000_CAFE);
    wr(9'h01C, 32'h1234_0055);
    rdchk("R3 aux unlocked", 9'h01C, 32'h1234_0055);
    wr(9'h014, 32'h1234_5678);
    rdchk("R2 key other", 9'h014, 32'h0000_5678);
    wr(9'h008, 32'h0000_0001);
    rdchk("R3 osc relocked", 9'h008, 32'h0000_CAFE);
  endtask

  task automatic t_ctrl;
    wr(9'h00C, 32'hFFFF_FFF7);
    rdchk("R4 ctrl bits", 9'h00C, 32'h0000_0005);
    check("R4 led on", {31'b0, led_on}, 32'h1);
    check("R6 flash off", {31'b0, boot_flash_en}, 32'h0);
    check("R5 no pulse bit3 clear", {31'b0, reset_req}, 32'h0);
    wr(9'h00C, 32'h0000_000A);
    check("R5 pulse high", {31'b0, reset_req}, 32'h1);
    rdchk("R4 bit3 reads zero", 9'h00C, 32'h0000_0000);
    check("R4 led off", {31'b0, led_on}, 32'h0);
    check("R6 flash on", {31'b0, boot_flash_en}, 32'h1);
    @(negedge clk);
    check("R5 pulse one cycle", {31'b0, reset_req}, 32'h0);
  endtask

  task automatic t_flags;
    wr(9'h030, 32'h0000_00F0);
    wr(9'h030, 32'h0000_000F);
    rdchk("R7 flags set", 9'h030, 32'h0000_00FF);
    wr(9'h034, 32'h0000_003C);
    rdchk("R7 flags clear", 9'h030, 32'h0000_00C3);
    wr(9'h038, 32'hA000_0001);
    wr(9'h03C, 32'h0000_0001);
    rdchk("R8 nvflags", 9'h038, 32'hA000_0000);
    rdchk("R8 flags independent", 9'h030, 32'h0000_00C3);
    rdchk("R13 clear addr reads zero", 9'h034, 32'h0);
    rdchk("R13 nv clear addr reads zero", 9'h03C, 32'h0);
  endtask

  task automatic t_sdram_init;
    wr(9'h020, 32'h89AB_CDEF);
    rdchk("R14 sdram", 9'h020, 32'h89AB_CDEF);
    wr(9'h024, 32'h0000_0777);
    rdchk("R14 init", 9'h024, 32'h0000_0777);
  endtask

  task automatic t_param;
    rdchk("R11 entry0", 9'h100, 32'd128);
    rdchk("R11 entry3", 9'h10C, 32'd11);
    rdchk("R11 entry30", 9'h178, 32'h28);
    rdchk("R11 entry31 64MB", 9'h17C, 32'd16);
    rdchk("R11 upper zero", 9'h180, 32'h0);
    rdchk("R11 upper end zero", 9'h1FC, 32'h0);
  endtask

  task automatic t_size(input logic [11:0] mb, input logic [31:0] sd, input logic [31:0] e31);
    do_reset(mb);
    rdchk("R10 sdram size", 9'h020, sd);
    rdchk("R11 entry31 size", 9'h17C, e31);
  endtask

  task automatic t_volt_unmapped;
    wr(9'h014, 32'h0000_A05F);
    wr(9'h008, 32'h0000_0042);
    for (int i = 0; i < 4; i++) begin
      wr(9'(9'h080 + 4 * i), 32'hFFFF_FFFF);
      rdchk("R12 volt zero", 9'(9'h080 + 4 * i), 32'h0);
    end
    wr(9'h018, 32'hFFFF_FFFF);
    check("R13 no pulse", {31'b0, reset_req}, 32'h0);
    wr(9'h028, 32'hFFFF_FFFF);
    wr(9'h040, 32'hFFFF_FFFF);
    rdchk("R13 word6 zero", 9'h018, 32'h0);
    rdchk("R13 word10 zero", 9'h028, 32'h0);
    rdchk("R13 word16 zero", 9'h040, 32'h0);
    rdchk("R12 R13 osc kept", 9'h008, 32'h0000_0042);
    rdchk("R12 R13 ctrl kept", 9'h00C, 32'h0);
    rdchk("R12 R13 flags kept", 9'h030, 32'h0);
    check("R12 R13 flash kept", {31'b0, boot_flash_en}, 32'h1);
  endtask

  initial begin
    do_reset(12'd100);
    t_reset_values();
    t_fixed();
    t_lock_osc();
    t_ctrl();
    t_flags();
    t_sdram_init();
    t_param();
    t_size(12'd300, 32'h0001_1132, 32'd64);
    t_size(12'd128, 32'h0001_112E, 32'd32);
    t_size(12'd32,  32'h0001_1126, 32'd4);
    t_size(12'd20,  32'h0001_1122, 32'd2);
    t_volt_unmapped();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule